// File: doc/BRIEF.md
# Systolic Horner Polynomial Evaluator

This block evaluates one fixed polynomial of degree n at a stream of points. It uses Horner's rule in a linear systolic array. A fresh sample x can enter on every clock. Each partial result then moves through n cell pairs. In each pair, a multiply cell scales the running value by that sample's own x, and an add cell then adds the next lower coefficient. Each cell has a pipeline register, so the array has 2n stages. Once the array is full, one result leaves it per clock.

Each sample enters at a different time, so a copy of its x travels next to its partial result through the pipeline registers. Every multiply cell therefore works with the x that belongs to the value it is processing. The coefficients come from a flat bank that the user holds steady while evaluations are in flight. The arithmetic is 16-bit two's complement by default, and all overflow wraps around.

Top module: `horner_array`

## Requirements
- R1: While rst_n is low, y_valid_o and y_o are 0. They stay 0 after reset is released until the first result arrives.
- R2: For a sample x, the result is (((a_n·x + a_{n-1})·x + …)·x + a_1)·x + a_0. Every product and every sum is kept modulo 2^16. Coefficient a_j sits in bits [16j+15:16j] of coef_i, so a_n is the top slice.
- R3: If x_valid_i is high in cycle t, then y_valid_o is high in cycle t+2n, with that sample's result. For the default degree 4 that is 8 cycles.
- R4: Samples presented in consecutive cycles give results in consecutive cycles. Each result uses only its own x.
- R5: A cycle with x_valid_i low gives a cycle with y_valid_o low 2n cycles later. The value on x_i in such a cycle has no effect on any result.
- R6: With the default idle mode, y_o is 0 whenever y_valid_o is low.
- R7: If reset is asserted while evaluations are in flight, they are discarded. No result for them ever appears.
- R8: Corner inputs are handled exactly. x = 0 gives a_0, x = 1 gives the sum of the coefficients, and x = -1 gives the alternating sum. x = 0x7FFF and x = 0x8000 wrap under R2.
- R9: The coefficient bank may change while nothing is in flight. Samples entering after the change use the new coefficients.
- R10: Every accepted sample produces exactly one result, and no result appears without a sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| coef_i | input | (DEG+1)*DW | Coefficient bank; a_j at bits [j*DW +: DW] |
| x_valid_i | input | 1 | Sample valid |
| x_i | input | DW | Sample x, two's complement |
| y_valid_o | output | 1 | Result valid |
| y_o | output | DW | Polynomial value, two's complement |

## Verification
When the stream is longer than 2n samples, the first multiply cell takes in a new sample in the same cycle that the last add cell delivers the result of a sample from 2n cycles earlier. The bench sets this up with a back-to-back run of twelve samples and with a run that has bubbles in it. It records the capture cycle and the independently computed Horner value of every accepted sample. Each result is then matched in order against its value and against a latency of exactly 2n cycles, so an x that slips one stage shows up as a wrong value on a result that overlaps a new input.

// File: rtl/horner_pkg.sv
package horner_pkg;

   // Behaviour of data registers in cycles without a valid sample
   typedef enum logic {
      IDLE_HOLD = 1'b0,   // data registers keep their last value
      IDLE_ZERO = 1'b1    // data registers are cleared
   } idle_mode_e;

   // Two register stages per coefficient step
   function automatic int pipe_depth(int deg);
      return 2 * deg;
   endfunction

endpackage

// File: rtl/horner_mul_cell.sv
module horner_mul_cell #(
   parameter int                     DW        = 16,
   parameter horner_pkg::idle_mode_e IDLE_MODE = horner_pkg::IDLE_ZERO
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          vld_i,
   input  logic [DW-1:0] x_i,
   input  logic [DW-1:0] acc_i,
   output logic          vld_o,
   output logic [DW-1:0] x_o,
   output logic [DW-1:0] prod_o
);

   logic [DW-1:0] prod_w;

   // Low DW bits of the product are identical for signed and unsigned operands
   assign prod_w = acc_i * x_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vld_o <= 1'b0;
      else        vld_o <= vld_i;
   end

   generate
      if (IDLE_MODE == horner_pkg::IDLE_ZERO) begin : g_zero
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               x_o    <= '0;
               prod_o <= '0;
            end else begin
               x_o    <= vld_i ? x_i    : '0;
               prod_o <= vld_i ? prod_w : '0;
            end
         end
      end else begin : g_hold
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               x_o    <= '0;
               prod_o <= '0;
            end else if (vld_i) begin
               x_o    <= x_i;
               prod_o <= prod_w;
            end
         end
      end
   endgenerate

   // R4
   x_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && vld_o) |-> (x_o == $past(x_i)));

endmodule

// File: rtl/horner_add_cell.sv
module horner_add_cell #(
   parameter int                     DW        = 16,
   parameter horner_pkg::idle_mode_e IDLE_MODE = horner_pkg::IDLE_ZERO
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          vld_i,
   input  logic [DW-1:0] x_i,
   input  logic [DW-1:0] prod_i,
   input  logic [DW-1:0] coef_i,
   output logic          vld_o,
   output logic [DW-1:0] x_o,
   output logic [DW-1:0] acc_o
);

   logic [DW-1:0] sum_w;

   assign sum_w = prod_i + coef_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vld_o <= 1'b0;
      else        vld_o <= vld_i;
   end

   generate
      if (IDLE_MODE == horner_pkg::IDLE_ZERO) begin : g_zero
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               x_o   <= '0;
               acc_o <= '0;
            end else begin
               x_o   <= vld_i ? x_i   : '0;
               acc_o <= vld_i ? sum_w : '0;
            end
         end

         // R6
         idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !vld_o |-> (acc_o == '0 && x_o == '0));
      end else begin : g_hold
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               x_o   <= '0;
               acc_o <= '0;
            end else if (vld_i) begin
               x_o   <= x_i;
               acc_o <= sum_w;
            end
         end
      end
   endgenerate

   // R3
   vld_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (vld_o == $past(vld_i)));

endmodule

// File: rtl/horner_pair.sv
module horner_pair #(
   parameter int                     DW        = 16,
   parameter horner_pkg::idle_mode_e IDLE_MODE = horner_pkg::IDLE_ZERO
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          vld_i,
   input  logic [DW-1:0] x_i,
   input  logic [DW-1:0] acc_i,
   input  logic [DW-1:0] coef_i,
   output logic          vld_o,
   output logic [DW-1:0] x_o,
   output logic [DW-1:0] acc_o
);

   logic          mid_vld;
   logic [DW-1:0] mid_x;
   logic [DW-1:0] mid_prod;

   horner_mul_cell #(.DW(DW), .IDLE_MODE(IDLE_MODE)) u_mul (
      .clk    (clk),
      .rst_n  (rst_n),
      .vld_i  (vld_i),
      .x_i    (x_i),
      .acc_i  (acc_i),
      .vld_o  (mid_vld),
      .x_o    (mid_x),
      .prod_o (mid_prod)
   );

   horner_add_cell #(.DW(DW), .IDLE_MODE(IDLE_MODE)) u_add (
      .clk    (clk),
      .rst_n  (rst_n),
      .vld_i  (mid_vld),
      .x_i    (mid_x),
      .prod_i (mid_prod),
      .coef_i (coef_i),
      .vld_o  (vld_o),
      .x_o    (x_o),
      .acc_o  (acc_o)
   );

endmodule

// File: rtl/horner_array.sv
module horner_array #(
   parameter int                     DEG       = 4,
   parameter int                     DW        = 16,
   parameter horner_pkg::idle_mode_e IDLE_MODE = horner_pkg::IDLE_ZERO
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [(DEG+1)*DW-1:0] coef_i,
   input  logic                  x_valid_i,
   input  logic [DW-1:0]         x_i,
   output logic                  y_valid_o,
   output logic [DW-1:0]         y_o
);

   localparam int STAGES = horner_pkg::pipe_depth(DEG);
   localparam int CW     = $clog2(STAGES + 2);

   generate
      if (DEG < 1) begin : g_bad_deg
         $error("horner_array: DEG must be at least 1");
      end
      if (DW < 2) begin : g_bad_dw
         $error("horner_array: DW must be at least 2");
      end
   endgenerate

   logic          vld_c [0:DEG];
   logic [DW-1:0] x_c   [0:DEG];
   logic [DW-1:0] acc_c [0:DEG];

   // Entry of the chain: leading coefficient seeds the running value
   assign vld_c[0] = x_valid_i;
   assign x_c[0]   = x_i;
   assign acc_c[0] = coef_i[DEG*DW +: DW];

   generate
      for (genvar k = 0; k < DEG; k++) begin : g_pair
         horner_pair #(.DW(DW), .IDLE_MODE(IDLE_MODE)) u_pair (
            .clk    (clk),
            .rst_n  (rst_n),
            .vld_i  (vld_c[k]),
            .x_i    (x_c[k]),
            .acc_i  (acc_c[k]),
            .coef_i (coef_i[(DEG-1-k)*DW +: DW]),
            .vld_o  (vld_c[k+1]),
            .x_o    (x_c[k+1]),
            .acc_o  (acc_c[k+1])
         );
      end
   endgenerate

   assign y_valid_o = vld_c[DEG];
   assign y_o       = acc_c[DEG];

   // Occupancy tracking for the checks below
   logic [CW-1:0] inflight;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) inflight <= '0;
      else        inflight <= inflight + CW'(x_valid_i) - CW'(y_valid_o);
   end

   // R10
   inflight_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      inflight <= CW'(STAGES));

   // R10
   orphan_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      y_valid_o |-> (inflight != '0));

   generate
      if (IDLE_MODE == horner_pkg::IDLE_ZERO) begin : g_tail_chk
         // R6
         tail_x_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !y_valid_o |-> (x_c[DEG] == '0));
      end
   endgenerate

endmodule

// File: tb/tb_horner_array.sv
module tb_horner_array;

   localparam int CLK_PERIOD = 10;
   localparam int DEG        = 4;
   localparam int DW         = 16;
   localparam int NC         = DEG + 1;
   localparam int LAT        = 2 * DEG;
   localparam int NTAB       = 12;

   // a4..a0 = 3, -2, 5, 1, -7
   localparam logic [NC*DW-1:0] COEF_A = {16'd3, 16'hFFFE, 16'd5, 16'd1, 16'hFFF9};
   // a4..a0 = 1, 0, -1, 0, 10
   localparam logic [NC*DW-1:0] COEF_B = {16'd1, 16'd0, 16'hFFFF, 16'd0, 16'd10};

   localparam logic [DW-1:0] XTAB [0:NTAB-1] = '{
      16'h0000, 16'h0001, 16'hFFFF, 16'h0002, 16'h0003, 16'hFFFE,
      16'h0007, 16'h7FFF, 16'h8000, 16'h0064, 16'h1234, 16'h0005
   };

   logic                 clk = 1'b0;
   logic                 rst_n;
   logic [NC*DW-1:0]     coef;
   logic                 x_valid;
   logic [DW-1:0]        x;
   logic                 y_valid;
   logic [DW-1:0]        y;

   int errors = 0;
   int checks = 0;
   bit done   = 1'b0;
   bit mon_en = 1'b0;

   logic [DW-1:0] exp_y [0:255];
   int            exp_c [0:255];
   int            wr_idx = 0;
   int            rd_idx = 0;
   int            pc     = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   horner_array #(.DEG(DEG), .DW(DW)) dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .coef_i    (coef),
      .x_valid_i (x_valid),
      .x_i       (x),
      .y_valid_o (y_valid),
      .y_o       (y)
   );

   function automatic logic [DW-1:0] ref_y(logic [DW-1:0] xv, logic [NC*DW-1:0] c);
      logic [DW-1:0] acc;
      acc = c[DEG*DW +: DW];
      for (int j = DEG - 1; j >= 0; j--) acc = acc * xv + c[j*DW +: DW];
      return acc;
   endfunction

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] expv);
      checks++;
      if (act !== expv) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
      end
   endtask

   // Record every accepted sample with its capture edge and reference value
   always @(posedge clk) begin
      if (rst_n && x_valid) begin
         exp_y[wr_idx & 255] = ref_y(x, coef);
         exp_c[wr_idx & 255] = pc;
         wr_idx++;
      end
      pc++;
   end

   // Compare results away from the active edge
   always @(negedge clk) begin
      if (mon_en) begin
         if (y_valid) begin
            if (rd_idx == wr_idx) begin
               chk("R10", "result without sample", 32'd1, 32'd0);
            end else begin
               chk("R2", "value", 32'(y), 32'(exp_y[rd_idx & 255]));
               // capture at edge P; visible after edge P+LAT-1, where pc = P+LAT
               chk("R3", "latency", 32'(pc - exp_c[rd_idx & 255]), 32'(LAT));
               rd_idx++;
            end
         end else begin
            chk("R6", "idle output", 32'(y), 32'd0);
         end
      end
   end

   task automatic drive(logic v, logic [DW-1:0] xv);
      @(negedge clk);
      x_valid = v;
      x       = xv;
   endtask

   task automatic drain();
      drive(1'b0, '0);
      repeat (LAT + 3) @(negedge clk);
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      rst_n   = 1'b0;
      coef    = COEF_A;
      x_valid = 1'b0;
      x       = '0;
      repeat (3) @(negedge clk);
      chk("R1", "valid in reset", 32'(y_valid), 32'd0);
      chk("R1", "data in reset", 32'(y), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "valid after release", 32'(y_valid), 32'd0);
      mon_en = 1'b1;

      // R4 R8: back-to-back table walk, corner x values included
      for (int i = 0; i < NTAB; i++) drive(1'b1, XTAB[i]);
      drain();
      chk("R10", "count after stream", 32'(rd_idx), 32'(wr_idx));
      chk("R8", "x=0 gives a0", 32'(ref_y(16'h0000, COEF_A)), 32'(16'hFFF9));
      chk("R8", "x=1 gives coef sum", 32'(ref_y(16'h0001, COEF_A)), 32'd0);

      // R5: bubbles with garbage on x_i while invalid
      for (int i = 0; i < 10; i++) begin
         if (i % 3 == 1) drive(1'b0, 16'hDEAD);
         else            drive(1'b1, 16'(i * 37 - 100));
      end
      drain();
      chk("R5", "count after bubbles", 32'(rd_idx), 32'(wr_idx));

      // R9: new coefficient set while pipeline empty
      @(negedge clk);
      coef = COEF_B;
      drive(1'b1, 16'd2);
      drive(1'b1, 16'hFFFD);
      drive(1'b1, 16'h8000);
      drive(1'b1, 16'd1);
      drain();
      chk("R9", "x=2 new set", 32'(ref_y(16'd2, COEF_B)), 32'd22);
      chk("R9", "count after change", 32'(rd_idx), 32'(wr_idx));

      // R7: reset with evaluations in flight
      drive(1'b1, 16'd4);
      drive(1'b1, 16'd5);
      drive(1'b1, 16'd6);
      drive(1'b0, '0);
      @(negedge clk);
      rst_n  = 1'b0;
      rd_idx = wr_idx;
      @(negedge clk);
      chk("R7", "valid during flush reset", 32'(y_valid), 32'd0);
      rst_n = 1'b1;
      begin
         int seen;
         seen = 0;
         for (int i = 0; i < 3 * LAT; i++) begin
            @(negedge clk);
            if (y_valid) seen++;
         end
         chk("R7", "results after flush", 32'(seen), 32'd0);
      end

      // R1: operation resumes after reset
      drive(1'b1, 16'd3);
      drain();
      chk("R10", "count after resume", 32'(rd_idx), 32'(wr_idx));

      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         summary();
         $finish;
      end
   end

endmodule